// File: doc/BRIEF.md
# Flash Status Register Unit

This block holds the eight-bit status word of a flash device that has several independently addressed banks. An internal program/erase sequencer feeds it with operation starts, completion and pause strobes, and error strobes. The command decoder feeds it with status-read, array-read, status-clear, suspend and resume commands. From these the block keeps three kinds of state: the bits that follow the sequencer, the error bits that stay set until they are cleared, and the suspend tracking.

On the read side, the block watches chip enable and output enable. When both become active it freezes a copy of the status word, and it keeps that copy on the data bus until either enable goes inactive again. A read returns the frozen status when the device is in status mode, or when the addressed bank has an operation in progress. Every other read passes array data through. The status byte goes out on the low eight bits of the bus, and the upper bits are driven to zero.

Top module: `fsr_unit`

## Requirements
- R1: Synchronous active-low reset sets the status word to 0x80 (ready, no suspend, no errors) and selects array read mode.
- R2: Bit 7 is 0 from the cycle after an operation start accepted in the idle state, and returns to 1 in the cycle after the completion strobe.
- R3: After a suspend command during an operation, bit 7 stays 0 until the pause strobe arrives and then reads 1. A completion strobe before the pause ends the operation with both suspend bits at 0.
- R4: Once a suspend is accepted, bit 6 reads 1 for an erase and bit 2 reads 1 for a program. A resume from the paused state clears that bit and takes bit 7 back to 0.
- R5: Error strobes err_i[3], err_i[2], err_i[1] and err_i[0] set bits 5 (erase), 4 (program), 3 (supply voltage) and 1 (block lock) in the next cycle. These bits accumulate by OR and stay set.
- R6: The clear-status command zeroes bits 5, 4, 3 and 1 and leaves bits 7, 6, 2 and 0 unchanged. An error strobe that arrives in the same cycle as the clear still sets its bit.
- R7: Bit 0 reads 1 when an operation is running or waiting to pause in the bank given by rd_bank_i at capture. It reads 0 for every other bank and while the operation is paused.
- R8: An access starts when ce_n_i and oe_n_i are both low after a cycle in which either was high. The status word is captured at that edge. From the next cycle the bus shows the captured value, unchanged until either enable goes high. With no access held, the bus is 0.
- R9: The status-read command enters status mode and the array-read command leaves it. A read returns status in status mode or when the addressed bank is busy (bit 0 set), and returns array_data_i otherwise.
- R10: A status read drives the status byte on rd_data_o[7:0] and zero on all upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| op_start_i | input | 1 | Sequencer starts an operation (strobe) |
| op_erase_i | input | 1 | Kind of the starting operation: 1 erase, 0 program |
| op_bank_i | input | BANK_W | Bank of the starting operation |
| op_done_i | input | 1 | Sequencer finished the operation (strobe) |
| op_paused_i | input | 1 | Sequencer has paused after a suspend (strobe) |
| err_i | input | 4 | Error strobes: [3] erase, [2] program, [1] supply, [0] lock |
| cmd_rdsr_i | input | 1 | Status-read command (enter status mode) |
| cmd_rdarr_i | input | 1 | Array-read command (leave status mode) |
| cmd_clr_i | input | 1 | Clear-status command |
| cmd_susp_i | input | 1 | Suspend command |
| cmd_resume_i | input | 1 | Resume command |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_bank_i | input | BANK_W | Bank addressed by the current read |
| array_data_i | input | DATA_W | Data from the array read path |
| rd_data_o | output | DATA_W | Read data bus |

## Verification
The assertions check several rules on every cycle. Error strobes set their bits and the bits stay set until a clear. A clear with no strobe empties the error bits. Bit 7 cannot rise while an operation runs unless a pause or completion strobe arrives. A start from idle and a resume from the paused state both drop bit 7. The bus does not move while a captured status word is being held. The bench scenarios cover what needs a whole sequence: suspend being overtaken by completion, set winning over clear, status being forced for the busy bank while the device is in array mode, and the bank-dependent bit 0 being frozen at capture while events change the live word.

// File: rtl/fsr_pkg.sv
// Shared definitions for the flash status register unit: sequencer state
// encoding, status bit positions and the reset value of the status word.
package fsr_pkg;

    // Sequencer tracking states: idle, running, suspend requested, paused.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_PEND = 2'd2,
        SEQ_HALT = 2'd3
    } seq_state_e;

    localparam int STAT_W = 8;
    localparam int ERR_N  = 4;

    // Status bit positions (fixed: software decodes them).
    localparam int SB_READY = 7;
    localparam int SB_ESUSP = 6;
    localparam int SB_EERR  = 5;
    localparam int SB_PERR  = 4;
    localparam int SB_VERR  = 3;
    localparam int SB_PSUSP = 2;
    localparam int SB_LERR  = 1;
    localparam int SB_BANK  = 0;

    // Error strobe index -> status bit position: lock, supply, program, erase.
    localparam int ERR_POS [ERR_N] = '{SB_LERR, SB_VERR, SB_PERR, SB_EERR};

    localparam logic [STAT_W-1:0] STAT_RESET = 8'h80;

endpackage

// File: rtl/fsr_seq_track.sv
// Tracks the program/erase sequencer as seen by the status word: whether an
// operation is in progress, its bank and kind, and the suspend handshake.
// Assumes the sequencer issues done only while running or waiting to pause,
// and paused only after a suspend has been requested.
module fsr_seq_track
    import fsr_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic [BANK_W-1:0] op_bank_i,
    input  logic              op_done_i,
    input  logic              op_paused_i,
    input  logic              cmd_susp_i,
    input  logic              cmd_resume_i,
    output logic              ready_o,
    output logic              esusp_o,
    output logic              psusp_o,
    output logic              active_o,
    output logic [BANK_W-1:0] act_bank_o
);

    seq_state_e        state_q, state_d;
    logic              erase_q;
    logic [BANK_W-1:0] bank_q;
    logic              susp_seen;

    // Next-state selection for the suspend-aware sequencer tracker.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (op_start_i) state_d = SEQ_RUN;
            SEQ_RUN: begin
                if (op_done_i)       state_d = SEQ_IDLE;
                else if (cmd_susp_i) state_d = SEQ_PEND;
            end
            SEQ_PEND: begin
                if (op_done_i)        state_d = SEQ_IDLE;
                else if (op_paused_i) state_d = SEQ_HALT;
            end
            SEQ_HALT: if (cmd_resume_i) state_d = SEQ_RUN;
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // Capture bank and kind of an operation when it is accepted from idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_q <= 1'b0;
            bank_q  <= '0;
        end else if (state_q == SEQ_IDLE && op_start_i) begin
            erase_q <= op_erase_i;
            bank_q  <= op_bank_i;
        end
    end

    assign susp_seen  = (state_q == SEQ_PEND) || (state_q == SEQ_HALT);
    assign ready_o    = (state_q == SEQ_IDLE) || (state_q == SEQ_HALT);
    assign esusp_o    = susp_seen && erase_q;
    assign psusp_o    = susp_seen && !erase_q;
    assign active_o   = (state_q == SEQ_RUN) || (state_q == SEQ_PEND);
    assign act_bank_o = bank_q;

endmodule

// File: rtl/fsr_err_flags.sv
// Sticky error flags. Each flag is set by its one-cycle strobe and cleared by
// the shared clear command; a set in the same cycle as a clear wins.
module fsr_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] flags_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic f_q;
        // One sticky flag: reset, set-over-clear priority, then hold.
        always_ff @(posedge clk) begin
            if (!rst_n)        f_q <= 1'b0;
            else if (set_i[g]) f_q <= 1'b1;
            else if (clr_i)    f_q <= 1'b0;
        end
        assign flags_o[g] = f_q;
    end

endmodule

// File: rtl/fsr_read_port.sv
// Read-side capture: detects the start of an access (both enables low after
// either was high), freezes the status word and the status/array choice,
// and drives the bus while the access is held. Assumes enables are already
// synchronous to clk.
module fsr_read_port #(
    parameter int DATA_W = 16,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic [STAT_W-1:0] live_stat_i,
    input  logic              want_stat_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              hold_o,
    output logic              sel_o
);

    localparam int PAD_W = DATA_W - STAT_W;

    logic              acc, acc_q, fall;
    logic              hold_q, sel_q;
    logic [STAT_W-1:0] snap_q;

    assign acc  = !ce_n_i && !oe_n_i;
    assign fall = acc && !acc_q;

    // Remember the previous access level to find the start of an access.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= 1'b0;
        else        acc_q <= acc;
    end

    // Freeze status and source choice at access start; drop hold on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            sel_q  <= 1'b0;
            snap_q <= '0;
        end else if (fall) begin
            hold_q <= 1'b1;
            sel_q  <= want_stat_i;
            snap_q <= live_stat_i;
        end else if (!acc) begin
            hold_q <= 1'b0;
        end
    end

    // Bus mux: zero when idle, captured status (zero extended) or array data.
    always_comb begin
        if (!hold_q)    rd_data_o = '0;
        else if (sel_q) rd_data_o = {{PAD_W{1'b0}}, snap_q};
        else            rd_data_o = array_data_i;
    end

    assign hold_o = hold_q;
    assign sel_o  = sel_q;

endmodule

// File: rtl/fsr_unit.sv
// Flash status register unit. Combines sequencer tracking, sticky error
// flags and the read capture port into the 8-bit status word, and decides
// per access whether status or array data is returned. Assumes all strobes
// and commands are single-cycle pulses synchronous to clk.
module fsr_unit
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BANKS  = 4,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start_i,
    input  logic              op_erase_i,
    input  logic [BANK_W-1:0] op_bank_i,
    input  logic              op_done_i,
    input  logic              op_paused_i,
    input  logic [ERR_N-1:0]  err_i,
    input  logic              cmd_rdsr_i,
    input  logic              cmd_rdarr_i,
    input  logic              cmd_clr_i,
    input  logic              cmd_susp_i,
    input  logic              cmd_resume_i,
    input  logic              ce_n_i,
    input  logic              oe_n_i,
    input  logic [BANK_W-1:0] rd_bank_i,
    input  logic [DATA_W-1:0] array_data_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic              ready, esusp, psusp, active;
    logic [BANK_W-1:0] act_bank;
    logic [ERR_N-1:0]  err_q;
    logic              bank_hit;
    logic              stat_mode_q;
    logic [STAT_W-1:0] live_stat;
    logic              rd_hold, rd_sel;

    fsr_seq_track #(.BANK_W(BANK_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start_i   (op_start_i),
        .op_erase_i   (op_erase_i),
        .op_bank_i    (op_bank_i),
        .op_done_i    (op_done_i),
        .op_paused_i  (op_paused_i),
        .cmd_susp_i   (cmd_susp_i),
        .cmd_resume_i (cmd_resume_i),
        .ready_o      (ready),
        .esusp_o      (esusp),
        .psusp_o      (psusp),
        .active_o     (active),
        .act_bank_o   (act_bank)
    );

    fsr_err_flags #(.N(ERR_N)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (err_i),
        .clr_i   (cmd_clr_i),
        .flags_o (err_q)
    );

    // R7: bank busy for the bank addressed by this read.
    assign bank_hit = active && (act_bank == rd_bank_i);

    // Assemble the live status word from device-owned and sticky bits.
    always_comb begin
        live_stat           = '0;
        live_stat[SB_READY] = ready;
        live_stat[SB_ESUSP] = esusp;
        live_stat[SB_PSUSP] = psusp;
        live_stat[SB_BANK]  = bank_hit;
        for (int i = 0; i < ERR_N; i++) begin
            live_stat[ERR_POS[i]] = err_q[i];
        end
    end

    // R9: status mode entered by status-read, left by array-read.
    always_ff @(posedge clk) begin
        if (!rst_n)           stat_mode_q <= 1'b0;
        else if (cmd_rdsr_i)  stat_mode_q <= 1'b1;
        else if (cmd_rdarr_i) stat_mode_q <= 1'b0;
    end

    fsr_read_port #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce_n_i       (ce_n_i),
        .oe_n_i       (oe_n_i),
        .live_stat_i  (live_stat),
        .want_stat_i  (stat_mode_q || bank_hit),
        .array_data_i (array_data_i),
        .rd_data_o    (rd_data_o),
        .hold_o       (rd_hold),
        .sel_o        (rd_sel)
    );

endmodule

// File: rtl/fsr_unit_chk.sv
// Property checker for fsr_unit, attached through bind. Observes the live
// status word, the strobes and the read port hold state.
module fsr_unit_chk
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] live_stat,
    input logic [ERR_N-1:0]  err_i,
    input logic              clr_i,
    input logic              start_i,
    input logic              done_i,
    input logic              paused_i,
    input logic              resume_i,
    input logic              hold,
    input logic              sel,
    input logic [DATA_W-1:0] rd_data
);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_stat[SB_READY] && !live_stat[SB_ESUSP] && !live_stat[SB_PSUSP] && start_i)
        |=> !live_stat[SB_READY]);

    // R3
    pend_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_stat[SB_READY] && !paused_i && !done_i) |=> !live_stat[SB_READY]);

    // R4
    resume_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_stat[SB_READY] && (live_stat[SB_ESUSP] || live_stat[SB_PSUSP]) && resume_i)
        |=> (!live_stat[SB_READY] && !live_stat[SB_ESUSP] && !live_stat[SB_PSUSP]));

    // R5
    erase_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i[3] |=> live_stat[SB_EERR]);

    // R5
    lock_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i[0] |=> live_stat[SB_LERR]);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_stat[SB_PERR] && !clr_i) |=> live_stat[SB_PERR]);

    // R6
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && err_i == '0) |=>
        (!live_stat[SB_EERR] && !live_stat[SB_PERR] && !live_stat[SB_VERR] && !live_stat[SB_LERR]));

    // R8
    snap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold) && sel) |-> $stable(rd_data));

endmodule

bind fsr_unit fsr_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .live_stat (live_stat),
    .err_i     (err_i),
    .clr_i     (cmd_clr_i),
    .start_i   (op_start_i),
    .done_i    (op_done_i),
    .paused_i  (op_paused_i),
    .resume_i  (cmd_resume_i),
    .hold      (rd_hold),
    .sel       (rd_sel),
    .rd_data   (rd_data_o)
);

// File: tb/fsr_unit_test.sv
// Bench for fsr_unit: directed corner cases, then seeded random stimulus,
// all compared against a bench model written from the requirements.
module fsr_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int BANKS      = 4;
    localparam int BANK_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              op_start, op_erase, op_done, op_paused;
    logic [BANK_W-1:0] op_bank, rd_bank;
    logic [3:0]        err;
    logic              rdsr, rdarr, clr, susp, resume;
    logic              ce_n, oe_n;
    logic [DATA_W-1:0] arr_d, rd_data;

    int n_chk = 0;
    int n_err = 0;

    // Bench model: 0 idle, 1 run, 2 suspend pending, 3 paused.
    int                m_st;
    logic [BANK_W-1:0] m_bank;
    logic              m_kind;
    logic [3:0]        m_err;
    logic              m_mode, m_hold, m_sel, m_accq;
    logic [7:0]        m_snap;

    fsr_unit #(.DATA_W(DATA_W), .BANKS(BANKS)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_start_i   (op_start),
        .op_erase_i   (op_erase),
        .op_bank_i    (op_bank),
        .op_done_i    (op_done),
        .op_paused_i  (op_paused),
        .err_i        (err),
        .cmd_rdsr_i   (rdsr),
        .cmd_rdarr_i  (rdarr),
        .cmd_clr_i    (clr),
        .cmd_susp_i   (susp),
        .cmd_resume_i (resume),
        .ce_n_i       (ce_n),
        .oe_n_i       (oe_n),
        .rd_bank_i    (rd_bank),
        .array_data_i (arr_d),
        .rd_data_o    (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mstat(logic [BANK_W-1:0] b);
        logic [7:0] s;
        s    = '0;
        s[7] = (m_st == 0) || (m_st == 3);
        s[6] = (m_st >= 2) && m_kind;
        s[2] = (m_st >= 2) && !m_kind;
        s[5] = m_err[3];
        s[4] = m_err[2];
        s[3] = m_err[1];
        s[1] = m_err[0];
        s[0] = ((m_st == 1) || (m_st == 2)) && (m_bank == b);
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] mout();
        if (!m_hold)   return '0;
        else if (m_sel) return {{(DATA_W-8){1'b0}}, m_snap};
        else           return arr_d;
    endfunction

    task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clr_in();
        op_start = 0; op_done = 0; op_paused = 0; err = '0;
        rdsr = 0; rdarr = 0; clr = 0; susp = 0; resume = 0;
    endtask

    // One clock: advance the model on the inputs now applied, then compare.
    task automatic step(string req);
        logic acc;
        int   n_st;
        n_st = m_st;
        acc  = !ce_n && !oe_n;
        if (!rst_n) begin
            m_st = 0; m_bank = '0; m_kind = 0; m_err = '0; m_mode = 0;
            m_hold = 0; m_sel = 0; m_accq = 0; m_snap = '0;
        end else begin
            if (acc && !m_accq) begin
                m_hold = 1;
                m_sel  = m_mode || mstat(rd_bank)[0];
                m_snap = mstat(rd_bank);
            end else if (!acc) m_hold = 0;
            m_accq = acc;
            case (m_st)
                0: if (op_start) begin n_st = 1; m_bank = op_bank; m_kind = op_erase; end
                1: if (op_done) n_st = 0; else if (susp) n_st = 2;
                2: if (op_done) n_st = 0; else if (op_paused) n_st = 3;
                default: if (resume) n_st = 1;
            endcase
            m_st  = n_st;
            m_err = clr ? err : (m_err | err);
            if (rdsr) m_mode = 1; else if (rdarr) m_mode = 0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(req, rd_data, mout());
    endtask

    task automatic pulse(string req);
        step(req);
        clr_in();
    endtask

    task automatic rd(string req, logic [BANK_W-1:0] b, logic [DATA_W-1:0] exp);
        rd_bank = b; ce_n = 0; oe_n = 0;
        step(req);
        chk(req, rd_data, exp);
        ce_n = 1; oe_n = 1;
        step(req);
    endtask

    task automatic run_all();
        clr_in();
        rst_n = 0; ce_n = 1; oe_n = 1; op_bank = '0; op_erase = 0;
        rd_bank = '0; arr_d = 16'hA5C3;
        @(negedge clk);
        for (int i = 0; i < 3; i++) step("R1");
        rst_n = 1;
        step("R1");
        // R1: reset gives array mode and status 0x80
        rd("R1", 2'd0, 16'hA5C3);
        rdsr = 1; pulse("R1");
        rd("R1", 2'd0, 16'h0080);
        // R2 / R7: program in bank 1
        op_start = 1; op_erase = 0; op_bank = 2'd1; pulse("R2");
        rd("R2", 2'd2, 16'h0000);
        rd("R7", 2'd1, 16'h0001);
        // R9: array mode, busy bank still returns status
        rdarr = 1; pulse("R9");
        rd("R9", 2'd1, 16'h0001);
        rd("R9", 2'd2, 16'hA5C3);
        op_done = 1; pulse("R2");
        rdsr = 1; pulse("R2");
        rd("R2", 2'd0, 16'h0080);
        // R3 / R4: erase suspend in bank 3
        op_start = 1; op_erase = 1; op_bank = 2'd3; pulse("R3");
        susp = 1; pulse("R3");
        rd("R3", 2'd0, 16'h0040);
        step("R3");
        rd("R3", 2'd3, 16'h0041);
        op_paused = 1; pulse("R3");
        rd("R4", 2'd3, 16'h00C0);
        resume = 1; pulse("R4");
        rd("R4", 2'd0, 16'h0000);
        rd("R4", 2'd3, 16'h0001);
        op_done = 1; pulse("R4");
        // R4: program suspend uses bit 2
        op_start = 1; op_erase = 0; op_bank = 2'd0; pulse("R4");
        susp = 1; pulse("R4");
        op_paused = 1; pulse("R4");
        rd("R4", 2'd0, 16'h0084);
        resume = 1; pulse("R4");
        // R3: completion overtakes suspend
        susp = 1; pulse("R3");
        op_done = 1; pulse("R3");
        rd("R3", 2'd0, 16'h0080);
        // R5: error accumulation
        err = 4'b0100; pulse("R5");
        rd("R5", 2'd0, 16'h0090);
        err = 4'b0001; pulse("R5");
        rd("R5", 2'd0, 16'h0092);
        err = 4'b1010; pulse("R5");
        rd("R5", 2'd0, 16'h00BA);
        // R6: set wins over clear, clear keeps device bits
        clr = 1; err = 4'b0010; pulse("R6");
        rd("R6", 2'd0, 16'h0088);
        clr = 1; pulse("R6");
        rd("R6", 2'd0, 16'h0080);
        op_start = 1; op_erase = 1; op_bank = 2'd2; pulse("R6");
        err = 4'b1000; pulse("R6");
        clr = 1; pulse("R6");
        rd("R6", 2'd2, 16'h0001);
        // R8: capture frozen while events change the live word
        rd_bank = 2'd2; ce_n = 0; oe_n = 0;
        step("R8");
        chk("R8", rd_data, 16'h0001);
        op_done = 1; step("R8"); clr_in();
        err = 4'b0100; step("R8"); clr_in();
        rd_bank = 2'd1; step("R8");
        chk("R8", rd_data, 16'h0001);
        oe_n = 1; step("R8");
        chk("R8", rd_data, 16'h0000);
        rd("R8", 2'd2, 16'h0090);
        // R10: upper bits zero on a status read
        rd_bank = 2'd0; ce_n = 0; oe_n = 0; arr_d = 16'hFFFF;
        step("R10");
        chk("R10", {8'h00, rd_data[15:8]}, 16'h0000);
        ce_n = 1; oe_n = 1; step("R10");
        clr = 1; pulse("R6");

        // Seeded random phase, model-checked every cycle.
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4000; c++) begin
            int r;
            clr_in();
            r = $urandom % 100;
            if (m_st == 0 && r < 20) begin
                op_start = 1; op_erase = $urandom % 2; op_bank = $urandom % BANKS;
            end
            if ((m_st == 1 || m_st == 2) && ($urandom % 100) < 8) op_done = 1;
            if (m_st == 2 && ($urandom % 100) < 30) op_paused = 1;
            if (($urandom % 100) < 10) susp = 1;
            if (($urandom % 100) < 10) resume = 1;
            if (($urandom % 100) < 6) err = 4'($urandom);
            if (($urandom % 100) < 5) clr = 1;
            if (($urandom % 100) < 5) rdsr = 1;
            if (($urandom % 100) < 5) rdarr = 1;
            arr_d   = 16'($urandom);
            rd_bank = $urandom % BANKS;
            if (ce_n || oe_n) begin
                if (($urandom % 100) < 30) begin ce_n = 0; oe_n = 0; end
            end else if (($urandom % 100) < 35) begin
                if ($urandom % 2) ce_n = 1; else oe_n = 1;
            end
            if (($urandom % 1000) < 3) rst_n = 0; else rst_n = 1;
            step("R8");
        end
        clr_in();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule